// File: doc/BRIEF.md
# Paged Memory Window Translator

This block turns host memory accesses into card memory accesses through five independently programmed windows with a granularity of 4 KB pages. Each window covers an inclusive range of host pages, from a start page to a stop page. A host address that falls inside an enabled window is translated by adding a per-window page offset, and the sum is wrapped to a 26-bit card address. Each window also carries a bus-width flag, a zero-wait flag, a two-bit wait-state count, a write-protect flag and an attribute-space select.

Software programs the windows through a single-cycle write port. Each write selects a window, one of three per-window words, or the shared enable word. For every host request the block returns, one clock later, a registered result. The result holds the hit flag, the index of the winning window, the translated address, the window's attributes and the wait-state count that a downstream cycle controller uses to stretch the access. It also holds either a card write strobe or a blocked-write flag.

Top module: `page_window_map`

## Requirements
- R1: While reset is held and after it is released, all result outputs are zero, all five windows are disabled and their words are zero.
- R2: A configuration write with `cfgWrEn` high loads `cfgData` into the word chosen by `cfgField`: 0 = start word, 1 = stop word, 2 = offset word of window `cfgWin`, 3 = the enable word (bit i enables window i, `cfgWin` ignored). A write with `cfgWin` of 5 or above to fields 0 to 2 changes no window.
- R3: Start word: bits [11:0] hold the start page (host address bits [23:12]), bit 15 is the 16-bit flag and bit 14 is the zero-wait flag. Stop word: bits [11:0] hold the stop page, and bits [15:14] hold the wait-state count. An enabled window hits every host address from start page × 4096 through stop page × 4096 + 0xFFF inclusive.
- R4: A window whose start page is greater than its stop page never hits, even when enabled. A window with equal start and stop pages covers exactly one page.
- R5: When several enabled windows hit, the lowest-numbered one supplies every result field and `hitWin`.
- R6: Offset word: bits [13:0] hold the page offset. The card address equals (host address + page offset × 4096) modulo 2^26.
- R7: On a hit, `attrSel` follows offset-word bit 14, `waitStates` follows stop-word bits [15:14], and `bus16` and `zeroWait` follow start-word bits 15 and 14.
- R8: Offset-word bit 15 write-protects a window. A write that hits such a window raises `wrBlocked` and leaves `cardWrStrobe` low, while reads of it translate normally with `wrBlocked` low.
- R9: A write that hits an unprotected window raises `cardWrStrobe`. On a miss, or when no request is presented, `hitValid`, `cardAddr`, `hitWin`, every attribute output, `cardWrStrobe` and `wrBlocked` are all zero.
- R10: A request sampled at a rising edge is reported from that edge until the next one. A cycle with `hostValid` low returns the outputs to the idle values of R9.
- R11: Clearing a window's enable bit removes its hits at once, and lower-priority overlapping windows then take over. Setting it makes the window hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write enable |
| cfgWin | input | 3 | Window index for per-window words |
| cfgField | input | 2 | Word select: 0 start, 1 stop, 2 offset, 3 enable |
| cfgData | input | 16 | Configuration write data |
| hostValid | input | 1 | Host request present this cycle |
| hostWrite | input | 1 | Request is a write |
| hostAddr | input | 24 | Host byte address |
| hitValid | output | 1 | Registered: request hit an enabled, valid window |
| hitWin | output | 3 | Index of winning window |
| cardAddr | output | 26 | Translated card address |
| attrSel | output | 1 | Attribute-space select |
| waitStates | output | 2 | Wait-state count of the winning window |
| bus16 | output | 1 | 16-bit flag of the winning window |
| zeroWait | output | 1 | Zero-wait flag of the winning window |
| wrBlocked | output | 1 | Write hit a write-protected window |
| cardWrStrobe | output | 1 | Write allowed to the card |

## Verification
The table probes addresses at the first and last byte of a window, inside two overlapping windows, one page past a stop page, and in an enabled window whose start lies above its stop. These tell range decoding apart from priority and from validity checking. Offsets large enough to overflow 26 bits separate correct modulo wrap from carry into a wider sum. Write and read requests to one protected window show that protection gates only the strobe. Directed steps then retarget out-of-range window indices, toggle enable bits on overlapping windows and drop `hostValid` to expose stale results.

// File: rtl/memwin_pkg.sv
package memwin_pkg;
  localparam int NUM_WIN  = 5;
  localparam int HOST_W   = 24;
  localparam int CARD_W   = 26;
  localparam int PG_BITS  = 12;
  localparam int PAGE_W   = HOST_W - PG_BITS;
  localparam int OFF_W    = CARD_W - PG_BITS;
  localparam int WS_W     = 2;
  localparam int DATA_W   = 16;
  localparam int IDX_W    = $clog2(NUM_WIN);

  // field positions inside the programming words
  localparam int B16_BIT  = 15;
  localparam int ZW_BIT   = 14;
  localparam int WS_LSB   = 14;
  localparam int WP_BIT   = 15;
  localparam int ATTR_BIT = 14;

  typedef enum logic [1:0] {
    FLD_START  = 2'd0,
    FLD_STOP   = 2'd1,
    FLD_OFFSET = 2'd2,
    FLD_ENABLE = 2'd3
  } cfgFld_e;

  typedef struct packed {
    logic              bus16;
    logic              zeroWait;
    logic [PAGE_W-1:0] startPage;
    logic [WS_W-1:0]   waitSt;
    logic [PAGE_W-1:0] stopPage;
    logic              wrProt;
    logic              attrSpace;
    logic [OFF_W-1:0]  pageOff;
  } winCfg_t;

  typedef struct packed {
    logic [NUM_WIN-1:0] ldStart;
    logic [NUM_WIN-1:0] ldStop;
    logic [NUM_WIN-1:0] ldOff;
    logic               ldEna;
    logic               reqTake;
    logic               reqWrite;
  } ctrlStb_t;
endpackage

// File: rtl/memwin_ctrl.sv
module memwin_ctrl
  import memwin_pkg::*;
#(
  parameter int NumWin = NUM_WIN,
  parameter int IdxW   = IDX_W
) (
  input  logic            cfgWrEn,
  input  logic [IdxW-1:0] cfgWin,
  input  logic [1:0]      cfgField,
  input  logic            hostValid,
  input  logic            hostWrite,
  output ctrlStb_t        stb
);
  cfgFld_e fld;
  logic [NumWin-1:0] winSel;

  assign fld = cfgFld_e'(cfgField);

  // one-hot window decode; indices past the last window select nothing
  always_comb begin
    winSel = '0;
    for (int i = 0; i < NumWin; i++) begin
      if (cfgWin == IdxW'(i)) winSel[i] = 1'b1;
    end
  end

  always_comb begin
    stb = '0;
    if (cfgWrEn) begin
      unique case (fld)
        FLD_START:  stb.ldStart = winSel;
        FLD_STOP:   stb.ldStop  = winSel;
        FLD_OFFSET: stb.ldOff   = winSel;
        FLD_ENABLE: stb.ldEna   = 1'b1;
        default:    stb.ldEna   = 1'b0;
      endcase
    end
    stb.reqTake  = hostValid;
    stb.reqWrite = hostValid & hostWrite;
  end
endmodule

// File: rtl/memwin_match.sv
module memwin_match
  import memwin_pkg::*;
#(
  parameter int PageW = PAGE_W
) (
  input  logic             winEna,
  input  logic [PageW-1:0] startPage,
  input  logic [PageW-1:0] stopPage,
  input  logic [PageW-1:0] hostPage,
  output logic             hit
);
  logic ordered;
  logic inRange;

  assign ordered = (startPage <= stopPage);
  assign inRange = (hostPage >= startPage) && (hostPage <= stopPage);
  assign hit     = winEna && ordered && inRange;
endmodule

// File: rtl/memwin_dp.sv
module memwin_dp
  import memwin_pkg::*;
#(
  parameter int NumWin = NUM_WIN,
  parameter int IdxW   = IDX_W,
  parameter int HostW  = HOST_W,
  parameter int CardW  = CARD_W,
  parameter int DataW  = DATA_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStb_t         stb,
  input  logic [DataW-1:0] cfgData,
  input  logic [HostW-1:0] hostAddr,
  output logic             hitValid,
  output logic [IdxW-1:0]  hitWin,
  output logic [CardW-1:0] cardAddr,
  output logic             attrSel,
  output logic [WS_W-1:0]  waitStates,
  output logic             bus16,
  output logic             zeroWait,
  output logic             wrBlocked,
  output logic             cardWrStrobe
);
  winCfg_t           cfgQ [NumWin];
  logic [NumWin-1:0] enaQ;
  logic [NumWin-1:0] winHit;
  logic [PAGE_W-1:0] hostPage;
  logic              anyHit;
  logic [IdxW-1:0]   selIdx;
  winCfg_t           selCfg;
  logic [CardW-1:0]  cardSum;
  logic              unusedCfgBits;

  assign unusedCfgBits = ^{cfgData[13:12], cfgData[DataW-1:NumWin]};
  assign hostPage = hostAddr[HostW-1:PG_BITS];

  // window register file
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NumWin; i++) cfgQ[i] <= '0;
      enaQ <= '0;
    end else begin
      for (int i = 0; i < NumWin; i++) begin
        if (stb.ldStart[i]) begin
          cfgQ[i].bus16     <= cfgData[B16_BIT];
          cfgQ[i].zeroWait  <= cfgData[ZW_BIT];
          cfgQ[i].startPage <= cfgData[PAGE_W-1:0];
        end
        if (stb.ldStop[i]) begin
          cfgQ[i].waitSt    <= cfgData[WS_LSB +: WS_W];
          cfgQ[i].stopPage  <= cfgData[PAGE_W-1:0];
        end
        if (stb.ldOff[i]) begin
          cfgQ[i].wrProt    <= cfgData[WP_BIT];
          cfgQ[i].attrSpace <= cfgData[ATTR_BIT];
          cfgQ[i].pageOff   <= cfgData[OFF_W-1:0];
        end
      end
      if (stb.ldEna) enaQ <= cfgData[NumWin-1:0];
    end
  end

  // one comparator pair per window
  for (genvar g = 0; g < NumWin; g++) begin : g_win
    memwin_match #(.PageW(PAGE_W)) u_match (
      .winEna    (enaQ[g]),
      .startPage (cfgQ[g].startPage),
      .stopPage  (cfgQ[g].stopPage),
      .hostPage  (hostPage),
      .hit       (winHit[g])
    );
  end

  // lowest index wins: scan downward so the last assignment is the lowest
  always_comb begin
    anyHit = 1'b0;
    selIdx = '0;
    for (int i = NumWin - 1; i >= 0; i--) begin
      if (winHit[i]) begin
        anyHit = 1'b1;
        selIdx = IdxW'(i);
      end
    end
  end

  always_comb begin
    selCfg = '0;
    for (int i = 0; i < NumWin; i++) begin
      if (selIdx == IdxW'(i)) selCfg = cfgQ[i];
    end
  end

  // offset added in page units, result wrapped to the card width
  assign cardSum = {{(CardW-HostW){1'b0}}, hostAddr}
                 + {selCfg.pageOff, {PG_BITS{1'b0}}};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hitValid     <= 1'b0;
      hitWin       <= '0;
      cardAddr     <= '0;
      attrSel      <= 1'b0;
      waitStates   <= '0;
      bus16        <= 1'b0;
      zeroWait     <= 1'b0;
      wrBlocked    <= 1'b0;
      cardWrStrobe <= 1'b0;
    end else if (stb.reqTake && anyHit) begin
      hitValid     <= 1'b1;
      hitWin       <= selIdx;
      cardAddr     <= cardSum;
      attrSel      <= selCfg.attrSpace;
      waitStates   <= selCfg.waitSt;
      bus16        <= selCfg.bus16;
      zeroWait     <= selCfg.zeroWait;
      wrBlocked    <= stb.reqWrite && selCfg.wrProt;
      cardWrStrobe <= stb.reqWrite && !selCfg.wrProt;
    end else begin
      hitValid     <= 1'b0;
      hitWin       <= '0;
      cardAddr     <= '0;
      attrSel      <= 1'b0;
      waitStates   <= '0;
      bus16        <= 1'b0;
      zeroWait     <= 1'b0;
      wrBlocked    <= 1'b0;
      cardWrStrobe <= 1'b0;
    end
  end
endmodule

// File: rtl/page_window_map.sv
module page_window_map
  import memwin_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgWrEn,
  input  logic [IDX_W-1:0]     cfgWin,
  input  logic [1:0]           cfgField,
  input  logic [DATA_W-1:0]    cfgData,
  input  logic                 hostValid,
  input  logic                 hostWrite,
  input  logic [HOST_W-1:0]    hostAddr,
  output logic                 hitValid,
  output logic [IDX_W-1:0]     hitWin,
  output logic [CARD_W-1:0]    cardAddr,
  output logic                 attrSel,
  output logic [WS_W-1:0]      waitStates,
  output logic                 bus16,
  output logic                 zeroWait,
  output logic                 wrBlocked,
  output logic                 cardWrStrobe
);
  ctrlStb_t stb;

  memwin_ctrl #(.NumWin(NUM_WIN), .IdxW(IDX_W)) u_ctrl (
    .cfgWrEn   (cfgWrEn),
    .cfgWin    (cfgWin),
    .cfgField  (cfgField),
    .hostValid (hostValid),
    .hostWrite (hostWrite),
    .stb       (stb)
  );

  memwin_dp #(
    .NumWin (NUM_WIN),
    .IdxW   (IDX_W),
    .HostW  (HOST_W),
    .CardW  (CARD_W),
    .DataW  (DATA_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .stb          (stb),
    .cfgData      (cfgData),
    .hostAddr     (hostAddr),
    .hitValid     (hitValid),
    .hitWin       (hitWin),
    .cardAddr     (cardAddr),
    .attrSel      (attrSel),
    .waitStates   (waitStates),
    .bus16        (bus16),
    .zeroWait     (zeroWait),
    .wrBlocked    (wrBlocked),
    .cardWrStrobe (cardWrStrobe)
  );
endmodule

// File: rtl/memwin_chk.sv
module memwin_chk
  import memwin_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              hostValid,
  input logic              hostWrite,
  input logic [HOST_W-1:0] hostAddr,
  input logic              hitValid,
  input logic [IDX_W-1:0]  hitWin,
  input logic [CARD_W-1:0] cardAddr,
  input logic              attrSel,
  input logic [WS_W-1:0]   waitStates,
  input logic              wrBlocked,
  input logic              cardWrStrobe
);
  AST_MISS_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !hitValid |-> (cardAddr == '0 && !cardWrStrobe && !wrBlocked && !attrSel && waitStates == '0)); // R9

  AST_WR_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rstN)
    !(cardWrStrobe && wrBlocked)); // R8

  AST_STROBE_FROM_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    cardWrStrobe |-> $past(hostValid && hostWrite)); // R9

  AST_BLOCK_FROM_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    wrBlocked |-> (hitValid && $past(hostValid && hostWrite))); // R8

  AST_HIT_FROM_REQ: assert property (@(posedge clk) disable iff (!rstN)
    hitValid |-> $past(hostValid)); // R10

  AST_WIN_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    hitValid |-> (int'(hitWin) < NUM_WIN)); // R5

  AST_PAGE_BYTE_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    hitValid |-> (cardAddr[PG_BITS-1:0] == $past(hostAddr[PG_BITS-1:0]))); // R6
endmodule

bind page_window_map memwin_chk u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .hostValid    (hostValid),
  .hostWrite    (hostWrite),
  .hostAddr     (hostAddr),
  .hitValid     (hitValid),
  .hitWin       (hitWin),
  .cardAddr     (cardAddr),
  .attrSel      (attrSel),
  .waitStates   (waitStates),
  .wrBlocked    (wrBlocked),
  .cardWrStrobe (cardWrStrobe)
);

// File: tb/page_window_map_tb.sv
`timescale 1ns/1ps
module page_window_map_tb;
  import memwin_pkg::*;

  typedef struct packed {
    logic        hit;
    logic [2:0]  win;
    logic [25:0] card;
    logic        attr;
    logic [1:0]  ws;
    logic        b16;
    logic        zw;
    logic        blk;
    logic        stb;
  } res_t;

  typedef struct packed {
    logic [3:0]  req;
    logic        wr;
    logic [23:0] addr;
    res_t        exp;
  } vec_t;

  localparam res_t MISS = '0;
  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{4'd3,  1'b0, 24'h010000, '{1'b1, 3'd0, 26'h0110000, 1'b0, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0}}, // R3 R6 R7 first byte
    '{4'd3,  1'b1, 24'h01FFFF, '{1'b1, 3'd0, 26'h011FFFF, 1'b0, 2'd2, 1'b1, 1'b0, 1'b0, 1'b1}}, // R3 R9 last byte
    '{4'd5,  1'b1, 24'h018123, '{1'b1, 3'd0, 26'h0118123, 1'b0, 2'd2, 1'b1, 1'b0, 1'b0, 1'b1}}, // R5 overlap
    '{4'd8,  1'b1, 24'h020456, '{1'b1, 3'd1, 26'h001F456, 1'b1, 2'd3, 1'b0, 1'b1, 1'b1, 1'b0}}, // R8 R6 wrap
    '{4'd8,  1'b0, 24'h030FFF, '{1'b1, 3'd1, 26'h002FFFF, 1'b1, 2'd3, 1'b0, 1'b1, 1'b0, 1'b0}}, // R8 R7 read
    '{4'd3,  1'b0, 24'h031000, MISS},                                                          // R3 past stop
    '{4'd4,  1'b0, 24'h045000, MISS},                                                          // R4 start>stop
    '{4'd6,  1'b1, 24'hFF0000, '{1'b1, 3'd3, 26'h0EF0000, 1'b0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1}}, // R6 wrap
    '{4'd6,  1'b0, 24'hFFFFFF, '{1'b1, 3'd3, 26'h0EFFFFF, 1'b0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0}}, // R6 top
    '{4'd11, 1'b1, 24'h100000, MISS},                                                          // R11 disabled
    '{4'd9,  1'b1, 24'h00FFFF, MISS}                                                           // R9 write miss
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWrEn = 1'b0;
  logic [2:0] cfgWin = '0;
  logic [1:0] cfgField = '0;
  logic [15:0] cfgData = '0;
  logic hostValid = 1'b0;
  logic hostWrite = 1'b0;
  logic [23:0] hostAddr = '0;
  logic hitValid, attrSel, bus16, zeroWait, wrBlocked, cardWrStrobe;
  logic [2:0] hitWin;
  logic [25:0] cardAddr;
  logic [1:0] waitStates;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  page_window_map u_dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWin(cfgWin),
    .cfgField(cfgField), .cfgData(cfgData), .hostValid(hostValid),
    .hostWrite(hostWrite), .hostAddr(hostAddr), .hitValid(hitValid),
    .hitWin(hitWin), .cardAddr(cardAddr), .attrSel(attrSel),
    .waitStates(waitStates), .bus16(bus16), .zeroWait(zeroWait),
    .wrBlocked(wrBlocked), .cardWrStrobe(cardWrStrobe)
  );

  function automatic res_t actual();
    return '{hitValid, hitWin, cardAddr, attrSel, waitStates, bus16, zeroWait, wrBlocked, cardWrStrobe};
  endfunction

  task automatic check(input string tag, input res_t exp);
    res_t act;
    act = actual();
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [2:0] w, input logic [1:0] f, input logic [15:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgWin = w; cfgField = f; cfgData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  // drive one request, sample its registered result one edge later
  task automatic access(input logic wr, input logic [23:0] a);
    @(negedge clk);
    hostValid = 1'b1; hostWrite = wr; hostAddr = a;
    @(negedge clk);
    hostValid = 1'b0; hostWrite = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 outputs during reset", MISS);
    rstN = 1'b1;
    access(1'b1, 24'h010000);
    check("R1 all windows off after reset", MISS);

    cfgWrite(3'd0, 2'd0, 16'h8010);
    cfgWrite(3'd0, 2'd1, 16'h801F);
    cfgWrite(3'd0, 2'd2, 16'h0100);
    cfgWrite(3'd1, 2'd0, 16'h4018);
    cfgWrite(3'd1, 2'd1, 16'hC030);
    cfgWrite(3'd1, 2'd2, 16'hFFFF);
    cfgWrite(3'd2, 2'd0, 16'h0050);
    cfgWrite(3'd2, 2'd1, 16'h0040);
    cfgWrite(3'd3, 2'd0, 16'h0FF0);
    cfgWrite(3'd3, 2'd1, 16'h4FFF);
    cfgWrite(3'd3, 2'd2, 16'h3F00);
    cfgWrite(3'd4, 2'd0, 16'h0100);
    cfgWrite(3'd4, 2'd1, 16'h0100);
    cfgWrite(3'd0, 2'd3, 16'h000F);

    for (int i = 0; i < NV; i++) begin
      access(VECS[i].wr, VECS[i].addr);
      check($sformatf("R%0d vector %0d", VECS[i].req, i), VECS[i].exp);
    end

    // R10: result held for one cycle only, idle cycle clears it
    access(1'b0, 24'h010000);
    check("R10 result after request", '{1'b1, 3'd0, 26'h0110000, 1'b0, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0});
    @(negedge clk);
    check("R10 idle cycle clears result", MISS);

    // R2: out-of-range window index must not touch any window
    cfgWrite(3'd5, 2'd0, 16'h0031);
    cfgWrite(3'd6, 2'd1, 16'h0000);
    cfgWrite(3'd7, 2'd2, 16'h0000);
    access(1'b0, 24'h030000);
    check("R2 index 5..7 ignored", '{1'b1, 3'd1, 26'h002F000, 1'b1, 2'd3, 1'b0, 1'b1, 1'b0, 1'b0});

    // R11 / R4: enable single-page window 4
    cfgWrite(3'd0, 2'd3, 16'h001F);
    access(1'b1, 24'h100ABC);
    check("R11 R4 window 4 enabled", '{1'b1, 3'd4, 26'h0100ABC, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1});
    access(1'b0, 24'h101000);
    check("R4 single page ends", MISS);

    // R11 / R5: drop window 0, overlap falls to window 1
    cfgWrite(3'd0, 2'd3, 16'h001E);
    access(1'b0, 24'h010000);
    check("R11 window 0 disabled", MISS);
    access(1'b1, 24'h018000);
    check("R11 R5 overlap falls to window 1", '{1'b1, 3'd1, 26'h0017000, 1'b1, 2'd3, 1'b0, 1'b1, 1'b1, 1'b0});

    // R9: no request presented
    @(negedge clk);
    hostAddr = 24'h020000; hostWrite = 1'b1;
    @(negedge clk);
    check("R9 hostValid low", MISS);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule